// File: doc/BRIEF.md
# Processor Status Flags Register

This block holds the 16-bit flags word of a small processor core and keeps it up to date. After an add or subtract, the ALU presents both operands, the result it produced, the operation kind and the operand size (byte or word). From these the block works out six arithmetic status flags and stores them at fixed bit positions. No arithmetic is repeated except what each flag needs. The same word also holds three control flags and a few stored-only fields. A direct-load path writes the whole word at once, for example on a pop-flags or return-from-interrupt instruction.

The control flags act on neighbouring logic through three outputs:

- The trap flag drives a single-step sequencer. It raises a trap request once the next instruction completes, and acknowledging the trap clears the flag.
- The interrupt-enable flag gates incoming maskable interrupt requests.
- The direction flag selects whether string index registers step up or down.

Top module: `flagreg_unit`

## Requirements
- R1: A synchronous reset makes `flags` read 16'h0002 on the next clock, with `step_req` low and the single-step sequencer disarmed.
- R2: Bit 1 of `flags` always reads one, and bits 3, 5 and 15 always read zero, whatever is loaded.
- R3: When `load_en` is high, bits 0, 2, 4, 6–14 of `flags` take `load_data` on the next clock, overriding any arithmetic update in that cycle.
- R4: On an arithmetic update, bit 0 (carry) is set exactly when the operation carries out of, or borrows into, the top bit (bit 7 for byte size, bit 15 for word size). A subtract is `alu_a - alu_b - borrow_in` and an add is `alu_a + alu_b + carry_in`, with the incoming carry implied by `alu_res`.
- R5: On an arithmetic update, bit 2 (parity) is set exactly when `alu_res[7:0]` has an even number of ones, for either size.
- R6: On an arithmetic update, bit 4 (half carry) is set exactly when the operation carries out of, or borrows into, the low four bits.
- R7: On an arithmetic update, bit 6 (zero) is set exactly when the sized result is zero, and bit 7 (sign) equals the sized result's top bit. The upper result byte is ignored for byte size.
- R8: On an arithmetic update, bit 11 (overflow) is set exactly when the signed result does not fit in the operand size.
- R9: An arithmetic update changes only bits 0, 2, 4, 6, 7, 11. With neither `load_en`, `alu_en` nor `trap_ack` high, `flags` holds.
- R10: Each `instr_done` pulse arms the single-step sequencer with the trap flag (bit 8) as it stands after that clock. An `instr_done` while armed sets `step_req` on the next clock, and `step_req` stays high until `trap_ack`.
- R11: `trap_ack` clears bit 8, `step_req` and the arming on the next clock, overriding a load of bit 8 in the same cycle.
- R12: `int_accept` equals `int_req` AND bit 9 (interrupt enable), combinationally.
- R13: `str_delta` is 2'b11 (minus one) when bit 10 (direction) is set and 2'b01 (plus one) when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_en | input | 1 | Apply an arithmetic status update this cycle |
| alu_sub | input | 1 | 1 = subtract, 0 = add |
| alu_byte | input | 1 | 1 = byte size, 0 = word size |
| alu_a | input | 16 | First operand |
| alu_b | input | 16 | Second operand |
| alu_res | input | 16 | Result produced by the ALU |
| load_en | input | 1 | Direct load of the flags word |
| load_data | input | 16 | Word to load |
| instr_done | input | 1 | An instruction completes this cycle |
| trap_ack | input | 1 | Single-step trap is being taken |
| int_req | input | 1 | Maskable interrupt request |
| flags | output | 16 | Current flags word |
| step_req | output | 1 | Single-step trap request |
| int_accept | output | 1 | Gated interrupt request |
| str_delta | output | 2 | String index step, two's complement |

## Verification
The arithmetic flags are tried with seeded random operands of both sizes, with an incoming carry or borrow of zero or one. For byte operations the high bytes carry random values, which shows that they are ignored. Directed cases sit on the edges where the flags part ways:

- signed wrap at 16'h7FFF+1 and 8'h80-1, which separates overflow from carry;
- an unsigned wrap to zero, which separates carry and zero from sign;
- a borrow from zero, which raises carry, half carry and sign together.

A load in the same cycle as an update shows which one wins. Trap-flag sequences show that the request waits one full instruction and that an acknowledge overrides a load.

// File: rtl/flagreg_pkg.sv
package flagreg_pkg;
  localparam int FW = 16;

  localparam int B_CF = 0;
  localparam int B_PF = 2;
  localparam int B_AF = 4;
  localparam int B_ZF = 6;
  localparam int B_SF = 7;
  localparam int B_TF = 8;
  localparam int B_IF = 9;
  localparam int B_DF = 10;
  localparam int B_OF = 11;
  localparam int B_PL0 = 12;
  localparam int B_PL1 = 13;
  localparam int B_NT = 14;
  localparam int B_ONE = 1;

  localparam logic [FW-1:0] STAT_MASK =
    (FW'(1) << B_CF) | (FW'(1) << B_PF) | (FW'(1) << B_AF) |
    (FW'(1) << B_ZF) | (FW'(1) << B_SF) | (FW'(1) << B_OF);
  localparam logic [FW-1:0] CTRL_MASK =
    (FW'(1) << B_TF) | (FW'(1) << B_IF) | (FW'(1) << B_DF) |
    (FW'(1) << B_PL0) | (FW'(1) << B_PL1) | (FW'(1) << B_NT);
  localparam logic [FW-1:0] WR_MASK  = STAT_MASK | CTRL_MASK;
  localparam logic [FW-1:0] ONE_MASK = FW'(1) << B_ONE;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

  // Carry (add) or borrow (sub) leaving the top bit, from the top operand
  // bits and the carry entering that bit.
  function automatic logic top_carry(input logic am, input logic bm,
                                     input logic cin_top, input logic sub);
    if (sub) return (~am & bm) | (~(am ^ bm) & cin_top);
    return (am & bm) | ((am ^ bm) & cin_top);
  endfunction

  // Signed range violation from the operand and result sign bits.
  function automatic logic sign_ovf(input logic am, input logic bm,
                                    input logic rm, input logic sub);
    if (sub) return (am != bm) && (rm != am);
    return (am == bm) && (rm != am);
  endfunction

  function automatic logic even_ones8(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic [FW-1:0] place_stat(input stat_t s);
    logic [FW-1:0] w;
    w = '0;
    w[B_CF] = s.cf;
    w[B_PF] = s.pf;
    w[B_AF] = s.af;
    w[B_ZF] = s.zf;
    w[B_SF] = s.sf;
    w[B_OF] = s.of;
    return w;
  endfunction
endpackage

// File: rtl/flagreg_arith.sv
module flagreg_arith
  import flagreg_pkg::*;
#(
  parameter int W = FW
) (
  input  logic         sub,
  input  logic         byte_op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] r,
  output stat_t        st
);
  localparam int MSB_W = W - 1;
  localparam int MSB_B = 7;
  localparam int NIB   = 4;

  logic [W-1:0] carry_in_vec;
  logic am, bm, rm, cin_top;
  logic zero_byte, zero_word;

  // For add or subtract, each result bit is a ^ b ^ (carry/borrow entering it).
  assign carry_in_vec = a ^ b ^ r;
  assign am      = byte_op ? a[MSB_B] : a[MSB_W];
  assign bm      = byte_op ? b[MSB_B] : b[MSB_W];
  assign rm      = byte_op ? r[MSB_B] : r[MSB_W];
  assign cin_top = byte_op ? carry_in_vec[MSB_B] : carry_in_vec[MSB_W];
  assign zero_byte = (r[MSB_B:0] == '0);
  assign zero_word = (r == '0);

  always_comb begin
    st.cf = top_carry(am, bm, cin_top, sub);
    st.pf = even_ones8(r[7:0]);
    st.af = carry_in_vec[NIB];
    st.zf = byte_op ? zero_byte : zero_word;
    st.sf = rm;
    st.of = sign_ovf(am, bm, rm, sub);
  end
endmodule

// File: rtl/flagreg_store.sv
module flagreg_store
  import flagreg_pkg::*;
#(
  parameter int W = FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         alu_en,
  input  stat_t        st,
  input  logic         trap_ack,
  output logic [W-1:0] q,
  output logic         tf_next
);
  localparam logic [W-1:0] WMASK = W'(WR_MASK);
  localparam logic [W-1:0] OMASK = W'(ONE_MASK);
  localparam logic [W-1:0] SMASK = W'(STAT_MASK);
  localparam logic [W-1:0] CMASK = W'(CTRL_MASK);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (load_en)     nxt = load_data;
    else if (alu_en) nxt = (q & ~SMASK) | W'(place_stat(st));
    if (trap_ack)    nxt[B_TF] = 1'b0;
    nxt = (nxt & WMASK) | OMASK;
  end

  assign tf_next = nxt[B_TF];

  always_ff @(posedge clk) begin
    if (rst) q <= OMASK;
    else     q <= nxt;
  end

  AST_RESET_VAL: assert property (@(posedge clk) rst |=> q == OMASK); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en && !trap_ack |=> (q & WMASK) == ($past(load_data) & WMASK)); // R3
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (rst)
    !load_en && !trap_ack |=> (q & CMASK) == ($past(q) & CMASK)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_en && !alu_en && !trap_ack |=> $stable(q)); // R9
  AST_ACK_CLR_TF: assert property (@(posedge clk) disable iff (rst)
    trap_ack |=> !q[B_TF]); // R11
endmodule

// File: rtl/flagreg_step.sv
module flagreg_step (
  input  logic clk,
  input  logic rst,
  input  logic instr_done,
  input  logic trap_ack,
  input  logic tf_next,
  output logic armed,
  output logic step_req
);
  always_ff @(posedge clk) begin
    if (rst || trap_ack) begin
      armed    <= 1'b0;
      step_req <= 1'b0;
    end else if (instr_done) begin
      if (armed) step_req <= 1'b1;
      armed <= tf_next;
    end
  end

  AST_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(step_req) |-> $past(instr_done) && $past(armed)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    step_req && !trap_ack |=> step_req); // R10
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    trap_ack |=> !step_req && !armed); // R11
endmodule

// File: rtl/flagreg_unit.sv
module flagreg_unit
  import flagreg_pkg::*;
#(
  parameter int W = FW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         alu_en,
  input  logic         alu_sub,
  input  logic         alu_byte,
  input  logic [W-1:0] alu_a,
  input  logic [W-1:0] alu_b,
  input  logic [W-1:0] alu_res,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         instr_done,
  input  logic         trap_ack,
  input  logic         int_req,
  output logic [W-1:0] flags,
  output logic         step_req,
  output logic         int_accept,
  output logic [1:0]   str_delta
);
  stat_t arith_st;
  logic  tf_next;
  logic  step_armed;

  flagreg_arith #(.W(W)) u_arith (
    .sub     (alu_sub),
    .byte_op (alu_byte),
    .a       (alu_a),
    .b       (alu_b),
    .r       (alu_res),
    .st      (arith_st)
  );

  flagreg_store #(.W(W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_data (load_data),
    .alu_en    (alu_en),
    .st        (arith_st),
    .trap_ack  (trap_ack),
    .q         (flags),
    .tf_next   (tf_next)
  );

  flagreg_step u_step (
    .clk        (clk),
    .rst        (rst),
    .instr_done (instr_done),
    .trap_ack   (trap_ack),
    .tf_next    (tf_next),
    .armed      (step_armed),
    .step_req   (step_req)
  );

  assign int_accept = int_req & flags[B_IF];
  assign str_delta  = flags[B_DF] ? 2'b11 : 2'b01;

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    alu_en && !load_en && (alu_byte ? (alu_res[7:0] == 8'h00) : (alu_res == '0))
    |=> flags[B_ZF] && flags[B_PF]); // R7
  AST_STEP_CLEAR_TF: assert property (@(posedge clk) disable iff (rst)
    $rose(step_armed) |-> flags[B_TF]); // R10
endmodule

// File: tb/flagreg_unit_tb.sv
module flagreg_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        alu_en = 0, alu_sub = 0, alu_byte = 0;
  logic [15:0] alu_a = 0, alu_b = 0, alu_res = 0;
  logic        load_en = 0;
  logic [15:0] load_data = 0;
  logic        instr_done = 0, trap_ack = 0, int_req = 0;
  logic [15:0] flags;
  logic        step_req, int_accept;
  logic [1:0]  str_delta;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] exp_f = 16'h0002;
  logic        exp_armed = 1'b0;
  logic        exp_req = 1'b0;

  flagreg_unit u_dut (
    .clk(clk), .rst(rst), .alu_en(alu_en), .alu_sub(alu_sub), .alu_byte(alu_byte),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res), .load_en(load_en),
    .load_data(load_data), .instr_done(instr_done), .trap_ack(trap_ack),
    .int_req(int_req), .flags(flags), .step_req(step_req),
    .int_accept(int_accept), .str_delta(str_delta)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Status bits from plain integer arithmetic on the sized operands.
  function automatic logic [15:0] ref_stat(input logic [15:0] a, input logic [15:0] b,
                                           input logic cin, input logic sub, input logic byt);
    int w, mask, ua, ub, full, rr, sa, sb, sres;
    logic [15:0] s;
    w = byt ? 8 : 16;
    mask = (1 << w) - 1;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    s = 16'h0;
    if (sub) begin
      full  = ua - ub - int'(cin);
      s[0]  = (ua < ub + int'(cin));
      s[4]  = ((ua & 15) < (ub & 15) + int'(cin));
    end else begin
      full  = ua + ub + int'(cin);
      s[0]  = (full > mask);
      s[4]  = ((ua & 15) + (ub & 15) + int'(cin) > 15);
    end
    rr = full & mask;
    sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
    sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
    sres = sub ? sa - sb - int'(cin) : sa + sb + int'(cin);
    s[11] = (sres > (1 << (w - 1)) - 1) || (sres < -(1 << (w - 1)));
    s[6]  = (rr == 0);
    s[7]  = ((rr >> (w - 1)) & 1) == 1;
    s[2]  = ($countones(rr & 255) % 2) == 0;
    return s;
  endfunction

  task automatic cyc(input logic ld, input logic [15:0] ldd, input logic ae,
                     input logic sub, input logic byt, input logic [15:0] a,
                     input logic [15:0] b, input logic cin, input logic done,
                     input logic ack, input logic ireq);
    logic [15:0] r, nf;
    logic [7:0]  rb;
    @(negedge clk);
    if (byt) begin
      rb = sub ? (a[7:0] - b[7:0] - {7'b0, cin}) : (a[7:0] + b[7:0] + {7'b0, cin});
      r = {8'($urandom), rb};
    end else begin
      r = sub ? (a - b - {15'b0, cin}) : (a + b + {15'b0, cin});
    end
    load_en = ld; load_data = ldd; alu_en = ae; alu_sub = sub; alu_byte = byt;
    alu_a = a; alu_b = b; alu_res = r; instr_done = done; trap_ack = ack; int_req = ireq;
    #1;
    chk("R12 int_accept", {15'b0, int_accept}, {15'b0, ireq & exp_f[9]});
    chk("R13 str_delta", {14'b0, str_delta}, exp_f[10] ? 16'h0003 : 16'h0001);
    nf = exp_f;
    if (ld)      nf = ldd;
    else if (ae) nf = (exp_f & ~16'h08D5) | ref_stat(a, b, cin, sub, byt);
    if (ack)     nf[8] = 1'b0;
    nf = (nf & 16'h7FD5) | 16'h0002;
    if (ack) begin
      exp_armed = 1'b0; exp_req = 1'b0;
    end else if (done) begin
      if (exp_armed) exp_req = 1'b1;
      exp_armed = nf[8];
    end
    exp_f = nf;
    @(posedge clk);
    #1;
    chk("R2 reserved bits", flags & 16'h802A, 16'h0002);
    if (ld) begin
      chk("R3 load", flags, exp_f);
    end else if (ae) begin
      chk("R4 carry", {15'b0, flags[0]}, {15'b0, exp_f[0]});
      chk("R5 parity", {15'b0, flags[2]}, {15'b0, exp_f[2]});
      chk("R6 half carry", {15'b0, flags[4]}, {15'b0, exp_f[4]});
      chk("R7 zero/sign", {14'b0, flags[7:6]}, {14'b0, exp_f[7:6]});
      chk("R8 overflow", {15'b0, flags[11]}, {15'b0, exp_f[11]});
      chk("R9 control kept", flags & 16'h7700, exp_f & 16'h7700);
    end else begin
      chk("R9 hold", flags, exp_f);
    end
    if (ack) chk("R11 ack", {flags[8], 14'b0, step_req}, {exp_f[8], 14'b0, exp_req});
    else     chk("R10 step_req", {15'b0, step_req}, {15'b0, exp_req});
  endtask

  task automatic idle(input logic done);
    cyc(0, 16'h0, 0, 0, 0, 16'h0, 16'h0, 0, done, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    load_en = 0; alu_en = 0; instr_done = 0; trap_ack = 0; int_req = 0;
    @(posedge clk);
    #1;
    exp_f = 16'h0002; exp_armed = 1'b0; exp_req = 1'b0;
    chk("R1 reset flags", flags, 16'h0002);
    chk("R1 reset step_req", {15'b0, step_req}, 16'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog (all) actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R3 / R2: full and empty loads
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 load all ones", flags, 16'h7FD7);
    cyc(1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 load zero", flags, 16'h0002);

    // R8 word signed wrap
    cyc(0, 0, 1, 0, 0, 16'h7FFF, 16'h0001, 0, 0, 0, 0);
    chk("R8 word 7FFF+1", flags, 16'h0896);
    // R4/R7 word unsigned wrap to zero
    cyc(0, 0, 1, 0, 0, 16'hFFFF, 16'h0001, 0, 0, 0, 0);
    chk("R4 word FFFF+1", flags, 16'h0057);
    // R7 byte wrap with junk high bytes
    cyc(0, 0, 1, 0, 1, 16'h12FF, 16'h3401, 0, 0, 0, 0);
    chk("R7 byte FF+1", flags, 16'h0057);
    // R8 byte subtract signed wrap
    cyc(0, 0, 1, 1, 1, 16'hAB80, 16'h0001, 0, 0, 0, 0);
    chk("R8 byte 80-1", flags, 16'h0812);
    // R6 word borrow from zero
    cyc(0, 0, 1, 1, 0, 16'h0000, 16'h0001, 0, 0, 0, 0);
    chk("R6 word 0-1", flags, 16'h0097);

    // R3 load beats arithmetic in the same cycle
    cyc(1, 16'h0700, 1, 0, 0, 16'hFFFF, 16'h0001, 0, 0, 0, 0);
    chk("R3 load over alu", flags, 16'h0702);
    // R9 control bits survive an update; R12/R13 with IF and DF set
    cyc(0, 0, 1, 0, 0, 16'h0001, 16'h0001, 0, 0, 0, 1);
    chk("R9 controls kept", flags & 16'h7700, 16'h0700);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R12 accept with IF", {15'b0, int_accept}, 16'h0001);
    chk("R13 decrement", {14'b0, str_delta}, 16'h0003);
    cyc(1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0);

    // R10 single step: set TF with the completing instruction
    cyc(1, 16'h0100, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 no request yet", {15'b0, step_req}, 16'h0);
    idle(0);
    idle(1);
    chk("R10 request after next instr", {15'b0, step_req}, 16'h0001);
    idle(0);
    chk("R10 request held", {15'b0, step_req}, 16'h0001);
    // R11 ack overrides a reload of TF
    cyc(1, 16'h0100, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R11 ack clears TF", {flags[8], 14'b0, step_req}, 16'h0);
    idle(1);
    chk("R10 disarmed after ack", {15'b0, step_req}, 16'h0);

    // R1 reset mid-run
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    do_reset();

    // Seeded random mix
    for (int i = 0; i < 1500; i++) begin
      logic ld, ae, ack;
      ld  = ($urandom % 10) == 0;
      ae  = ($urandom % 10) < 6;
      ack = exp_req ? (($urandom % 3) == 0) : (($urandom % 20) == 0);
      cyc(ld, 16'($urandom), ae, 1'($urandom), 1'($urandom), 16'($urandom),
          16'($urandom), 1'($urandom), ($urandom % 10) < 3, ack, 1'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule